// File: doc/BRIEF.md
# Security-Partitioned Priority Interrupt Controller

This block arbitrates a set of level-sensitive interrupt lines for a processor that runs in a secure and a non-secure state. Each line has an enable, a 4-bit priority (a smaller number means more urgent) and a security attribute. The attribute decides which exception output the line drives. It also protects the line's settings against non-secure software. Software sets up the block over a simple register bus. Every access on that bus carries a non-secure flag.

The processor claims the most urgent line with an acknowledge read. The priority of the claimed line becomes the running priority. An end-of-interrupt write restores the running priority that was in force before the claim, using a stack of nested claims. The two exception outputs are registered. Each output can instead follow an external legacy request input, and the two bypass choices are made independently. Setting a bypass also changes how the internal requests are routed to the output that is not bypassed.

Top module: `sec_prio_intc`

## Requirements
- R1: After reset both exception outputs are low. Every source is non-secure, disabled and at priority 0. No bypass is set. Reading the running priority (address 0x05) returns 16, the idle value.
- R2: The mode register (address 0x00: bit 0 bypasses the fast output, bit 1 bypasses the normal output) and the security register (address 0x01: bit i set marks source i as secure) change only on secure writes. Non-secure writes to them are ignored. A non-secure read of address 0x01 returns 0.
- R3: A non-secure write cannot change the enable bit (address 0x02, bit i) or the priority (address 0x10+i) of a secure source i. A non-secure read returns 0 in place of a secure source's enable bit and priority.
- R4: A non-secure write to the priority of a non-secure source stores the value with bit 3 forced to 1. A secure write stores any 4-bit value unchanged.
- R5: With no bypass, a source is a candidate when it is high, enabled, and its priority value is strictly below the running priority. A secure candidate raises the fast output and a non-secure candidate raises the normal output. Outputs follow the inputs and state one clock edge later.
- R6: A candidate whose priority value is equal to or above the running priority raises no output. It is forwarded once end-of-interrupt writes lower the running priority far enough.
- R7: An acknowledge read (address 0x03) returns the ID of the candidate with the smallest priority value, the lowest ID winning ties, and pushes that priority as the running priority. A non-secure acknowledge considers only non-secure candidates. If there is no eligible candidate, the read returns 16 and pushes nothing.
- R8: The running-priority stack holds 4 entries. An acknowledge while the stack is full returns 16 and pushes nothing. A write to address 0x04 pops one entry; when the stack is empty the write has no effect.
- R9: When only the fast output is bypassed, it follows the legacy fast input. All internal candidates, secure and non-secure, drive the normal output.
- R10: When only the normal output is bypassed, it follows the legacy normal input. Non-secure candidates raise no output, and secure candidates still drive the fast output.
- R11: When both outputs are bypassed, each follows its legacy input and the internal candidates have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level-sensitive interrupt lines |
| leg_fiq_i | input | 1 | External legacy fast request |
| leg_irq_i | input | 1 | External legacy normal request |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_ns_i | input | 1 | 1 = non-secure access |
| bus_addr_i | input | AW | Register address |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, registered |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
A write or a read takes effect at the clock edge of its access cycle. Read data is valid after that same edge. The bench drives each access at a falling edge and samples the data at the next falling edge. A change on a line or a legacy input reaches the exception outputs at the next rising edge. A register change, including a push or pop of the running priority, reaches the outputs one edge after the access, so every output check waits one falling edge beyond the last access or input change. The cases checked include equal-priority ties, a full stack and an EOI on an empty stack.

// File: rtl/sec_prio_intc.sv
module sec_prio_intc #(
  parameter int NSRC      = 16,
  parameter int PW        = 4,
  parameter int DEPTH     = 4,
  parameter int AW        = 8,
  parameter int DW        = 32,
  parameter int PRIO_BASE = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            leg_fiq_i,
  input  logic            leg_irq_i,
  input  logic            bus_en_i,
  input  logic            bus_we_i,
  input  logic            bus_ns_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            fiq_o,
  output logic            irq_o
);
  localparam int IW  = $clog2(NSRC);
  localparam int IDW = $clog2(NSRC + 1);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int RW  = PW + 1;
  localparam logic [RW-1:0]  IDLE = {1'b1, {PW{1'b0}}};
  localparam logic [IDW-1:0] SPUR = IDW'(NSRC);
  localparam logic [AW-1:0]  A_MODE = 8'h00, A_SEC = 8'h01, A_EN = 8'h02,
                             A_ACK = 8'h03, A_EOI = 8'h04, A_RUN = 8'h05;
  localparam logic [AW-1:0]  A_PB = AW'(PRIO_BASE);

  logic [1:0]      mode_q;
  logic [NSRC-1:0] sec_q, en_q, cand;
  logic [PW-1:0]   prio_q [NSRC];
  logic [RW-1:0]   stk_q  [DEPTH];
  logic [SPW-1:0]  sp_q;
  logic [RW-1:0]   run;

  wire wr = bus_en_i & bus_we_i;
  wire rd = bus_en_i & ~bus_we_i;
  wire [AW-1:0] poff = bus_addr_i - A_PB;
  wire p_hit = (bus_addr_i >= A_PB) && (poff < AW'(NSRC));
  wire [IW-1:0] pidx = poff[IW-1:0];

  always_comb begin
    run = IDLE;
    for (int k = 0; k < DEPTH; k++)
      if (SPW'(k) < sp_q) run = stk_q[k];
  end

  always_comb
    for (int i = 0; i < NSRC; i++)
      cand[i] = src_i[i] && en_q[i] && ({1'b0, prio_q[i]} < run);

  wire sec_req = |(cand & sec_q);
  wire ns_req  = |(cand & ~sec_q);

  logic           all_vld, ns_vld;
  logic [IDW-1:0] all_id, ns_id;
  logic [PW-1:0]  all_pr, ns_pr;

  always_comb begin
    all_vld = 1'b0; all_id = '0; all_pr = '0;
    ns_vld  = 1'b0; ns_id  = '0; ns_pr  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!all_vld || prio_q[i] < all_pr)) begin
        all_vld = 1'b1; all_id = IDW'(i); all_pr = prio_q[i];
      end
      if (cand[i] && !sec_q[i] && (!ns_vld || prio_q[i] < ns_pr)) begin
        ns_vld = 1'b1; ns_id = IDW'(i); ns_pr = prio_q[i];
      end
    end
  end

  wire           ack_vld = bus_ns_i ? ns_vld : all_vld;
  wire [IDW-1:0] ack_id  = bus_ns_i ? ns_id  : all_id;
  wire [PW-1:0]  ack_pr  = bus_ns_i ? ns_pr  : all_pr;
  wire           ack_ok  = ack_vld && (sp_q < SPW'(DEPTH));
  wire           do_ack  = rd && bus_addr_i == A_ACK;

  logic [DW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (bus_addr_i)
      A_MODE:  rd_val = DW'(mode_q);
      A_SEC:   rd_val = bus_ns_i ? '0 : DW'(sec_q);
      A_EN:    rd_val = DW'(bus_ns_i ? (en_q & ~sec_q) : en_q);
      A_ACK:   rd_val = DW'(ack_ok ? ack_id : SPUR);
      A_RUN:   rd_val = DW'(run);
      default: if (p_hit && !(bus_ns_i && sec_q[pidx])) rd_val = DW'(prio_q[pidx]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      sec_q <= '0;
      en_q <= '0;
      sp_q <= '0;
      bus_rdata_o <= '0;
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      for (int k = 0; k < DEPTH; k++) stk_q[k] <= IDLE;
    end else begin
      if (rd) bus_rdata_o <= rd_val;
      if (do_ack && ack_ok) begin
        for (int k = 0; k < DEPTH; k++)
          if (sp_q == SPW'(k)) stk_q[k] <= {1'b0, ack_pr};
        sp_q <= sp_q + SPW'(1);
      end
      if (wr) begin
        case (bus_addr_i)
          A_MODE: if (!bus_ns_i) mode_q <= bus_wdata_i[1:0];
          A_SEC:  if (!bus_ns_i) sec_q <= bus_wdata_i[NSRC-1:0];
          A_EN:   en_q <= bus_ns_i ? ((en_q & sec_q) | (bus_wdata_i[NSRC-1:0] & ~sec_q))
                                   : bus_wdata_i[NSRC-1:0];
          A_EOI:  if (sp_q != '0) sp_q <= sp_q - SPW'(1);
          default:
            if (p_hit) begin
              if (!bus_ns_i) prio_q[pidx] <= bus_wdata_i[PW-1:0];
              else if (!sec_q[pidx]) prio_q[pidx] <= {1'b1, bus_wdata_i[PW-2:0]};
            end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fiq_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      fiq_o <= mode_q[0] ? leg_fiq_i : sec_req;
      irq_o <= mode_q[1] ? leg_irq_i : (mode_q[0] ? (sec_req | ns_req) : ns_req);
    end
  end

  p_mode_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_ns_i && bus_addr_i == A_MODE) |=> $stable(mode_q));
  p_sec_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_ns_i && bus_addr_i == A_SEC) |=> $stable(sec_q));
  p_route_normal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |=> (fiq_o == $past(sec_req) && irq_o == $past(ns_req)));
  p_ack_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ack && ack_ok) |=> (run < $past(run)));
  p_stack_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (do_ack && sp_q == SPW'(DEPTH)) |=> (sp_q == SPW'(DEPTH)));
  p_eoi_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr_i == A_EOI && sp_q == '0) |=> (run == IDLE));
  p_fast_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[0] |=> (fiq_o == $past(leg_fiq_i)));
  p_normal_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q[1] |=> (irq_o == $past(leg_irq_i)));

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    p_prio_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_ns_i && p_hit && pidx == IW'(g) && sec_q[g]) |=> $stable(prio_q[g]));
    p_ns_prio_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_ns_i && p_hit && pidx == IW'(g) && !sec_q[g]) |=> prio_q[g][PW-1]);
  end
endmodule

// File: tb/tb_sec_prio_intc.sv
module tb_sec_prio_intc;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam bit S = 1'b0, NS = 1'b1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0;
  logic leg_fiq = 1'b0, leg_irq = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0, bus_ns = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fiq, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_prio_intc dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .leg_fiq_i(leg_fiq), .leg_irq_i(leg_irq),
    .bus_en_i(bus_en), .bus_we_i(bus_we), .bus_ns_i(bus_ns), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .fiq_o(fiq), .irq_o(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src = '0; leg_fiq = 1'b0; leg_irq = 1'b0; bus_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(bit ns, logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_ns = ns; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, bit ns, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_ns = ns; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic out_chk(string req, logic ef, logic ei);
    @(negedge clk);
    chk({req, " fast"}, 32'(fiq), 32'(ef));
    chk({req, " normal"}, 32'(irq), 32'(ei));
  endtask

  task automatic base_cfg();
    wr(S, 8'h01, 32'h0001);
    wr(S, 8'h10, 32'h2);
    wr(NS, 8'h15, 32'h1);
    wr(S, 8'h02, 32'h0021);
  endtask

  task automatic t_reset();
    do_reset();
    out_chk("R1 reset", 1'b0, 1'b0);
    rd_chk("R1 running idle", S, 8'h05, 32'd16);
    rd_chk("R1 mode", S, 8'h00, 32'd0);
    rd_chk("R1 security", S, 8'h01, 32'd0);
    rd_chk("R1 prio", S, 8'h13, 32'd0);
    rd_chk("R1 ack none", S, 8'h03, 32'd16);
  endtask

  task automatic t_regs();
    do_reset();
    wr(NS, 8'h01, 32'hFFFF);
    rd_chk("R2 ns security write", S, 8'h01, 32'd0);
    wr(NS, 8'h00, 32'h3);
    rd_chk("R2 ns mode write", S, 8'h00, 32'd0);
    wr(S, 8'h01, 32'h0003);
    rd_chk("R2 s security write", S, 8'h01, 32'h3);
    rd_chk("R2 ns security read", NS, 8'h01, 32'd0);
    wr(S, 8'h00, 32'h2);
    rd_chk("R2 s mode write", S, 8'h00, 32'h2);
  endtask

  task automatic t_lock();
    do_reset();
    wr(S, 8'h01, 32'h0001);
    wr(S, 8'h10, 32'h2);
    wr(S, 8'h02, 32'h0001);
    wr(NS, 8'h10, 32'hA);
    rd_chk("R3 ns prio write on secure", S, 8'h10, 32'h2);
    rd_chk("R3 ns prio read on secure", NS, 8'h10, 32'h0);
    wr(NS, 8'h02, 32'h0000);
    rd_chk("R3 ns enable clear on secure", S, 8'h02, 32'h1);
    wr(NS, 8'h02, 32'h0022);
    rd_chk("R3 ns enable of ns sources", S, 8'h02, 32'h23);
    rd_chk("R3 ns enable read masked", NS, 8'h02, 32'h22);
  endtask

  task automatic t_nsprio();
    do_reset();
    wr(NS, 8'h15, 32'h1);
    rd_chk("R4 ns prio msb", S, 8'h15, 32'h9);
    wr(NS, 8'h15, 32'h3);
    rd_chk("R4 ns prio 3", S, 8'h15, 32'hB);
    wr(S, 8'h15, 32'h1);
    rd_chk("R4 s prio any", S, 8'h15, 32'h1);
  endtask

  task automatic t_route();
    do_reset();
    base_cfg();
    src = 16'h0001;
    out_chk("R5 secure", 1'b1, 1'b0);
    src = 16'h0020;
    out_chk("R5 nonsecure", 1'b0, 1'b1);
    src = 16'h0021;
    out_chk("R5 both", 1'b1, 1'b1);
    src = 16'h0004;
    out_chk("R5 disabled", 1'b0, 1'b0);
  endtask

  task automatic t_prio();
    do_reset();
    base_cfg();
    wr(NS, 8'h16, 32'h1);
    wr(S, 8'h02, 32'h0061);
    src = 16'h0020;
    out_chk("R5 ns pending", 1'b0, 1'b1);
    rd_chk("R7 ns ack", NS, 8'h03, 32'd5);
    out_chk("R6 claimed masks", 1'b0, 1'b0);
    rd_chk("R7 running after ack", S, 8'h05, 32'd9);
    src = 16'h0060;
    out_chk("R6 equal prio waits", 1'b0, 1'b0);
    src = 16'h0061;
    out_chk("R6 higher preempts", 1'b1, 1'b0);
    rd_chk("R7 ns ack skips secure", NS, 8'h03, 32'd16);
    rd_chk("R7 no push on spurious", S, 8'h05, 32'd9);
    rd_chk("R7 s ack", S, 8'h03, 32'd0);
    rd_chk("R7 nested running", S, 8'h05, 32'd2);
    out_chk("R6 nested masks", 1'b0, 1'b0);
    wr(S, 8'h04, 32'h0);
    rd_chk("R8 eoi pop", S, 8'h05, 32'd9);
    out_chk("R6 secure returns", 1'b1, 1'b0);
    src = 16'h0060;
    wr(S, 8'h04, 32'h0);
    out_chk("R6 waiting forwarded", 1'b0, 1'b1);
    rd_chk("R7 tie lowest id", NS, 8'h03, 32'd5);
  endtask

  task automatic t_depth();
    do_reset();
    wr(S, 8'h01, 32'h001F);
    wr(S, 8'h10, 32'h0);
    wr(S, 8'h11, 32'h4);
    wr(S, 8'h12, 32'h3);
    wr(S, 8'h13, 32'h2);
    wr(S, 8'h14, 32'h1);
    wr(S, 8'h02, 32'h001F);
    src = 16'h0002; rd_chk("R8 nest 1", S, 8'h03, 32'd1);
    src = 16'h0006; rd_chk("R8 nest 2", S, 8'h03, 32'd2);
    src = 16'h000E; rd_chk("R8 nest 3", S, 8'h03, 32'd3);
    src = 16'h001E; rd_chk("R8 nest 4", S, 8'h03, 32'd4);
    rd_chk("R8 running at depth", S, 8'h05, 32'd1);
    src = 16'h001F;
    out_chk("R5 deeper pending", 1'b1, 1'b0);
    rd_chk("R8 ack when full", S, 8'h03, 32'd16);
    rd_chk("R8 full no push", S, 8'h05, 32'd1);
    for (int k = 0; k < 4; k++) wr(S, 8'h04, 32'h0);
    rd_chk("R8 all popped", S, 8'h05, 32'd16);
    wr(S, 8'h04, 32'h0);
    rd_chk("R8 eoi on empty", S, 8'h05, 32'd16);
    rd_chk("R7 best after unwind", S, 8'h03, 32'd0);
  endtask

  task automatic t_bypass();
    do_reset();
    base_cfg();
    wr(S, 8'h00, 32'h1);
    leg_fiq = 1'b1;
    out_chk("R9 legacy fast", 1'b1, 1'b0);
    leg_fiq = 1'b0; src = 16'h0001;
    out_chk("R9 secure to normal", 1'b0, 1'b1);
    src = 16'h0020;
    out_chk("R9 ns to normal", 1'b0, 1'b1);
    src = '0;
    wr(S, 8'h00, 32'h2);
    leg_irq = 1'b1;
    out_chk("R10 legacy normal", 1'b0, 1'b1);
    leg_irq = 1'b0; src = 16'h0020;
    out_chk("R10 ns no exception", 1'b0, 1'b0);
    src = 16'h0001;
    out_chk("R10 secure fast", 1'b1, 1'b0);
    wr(S, 8'h00, 32'h3);
    src = 16'h0021;
    out_chk("R11 internal ignored", 1'b0, 1'b0);
    leg_fiq = 1'b1; leg_irq = 1'b1;
    out_chk("R11 both legacy", 1'b1, 1'b1);
    leg_irq = 1'b0;
    out_chk("R11 fast only legacy", 1'b1, 1'b0);
    wr(NS, 8'h00, 32'h0);
    rd_chk("R2 ns mode write in bypass", S, 8'h00, 32'h3);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_lock();
    t_nsprio();
    t_route();
    t_prio();
    t_depth();
    t_bypass();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule